// File: doc/BRIEF.md
# Pipeline Exception Priority Controller

This block decides, once per cycle, what an instruction-fetch pipeline does next. It samples a set of status flags from around the pipeline: reset, bus fault and bus reject, the ALU condition, the operand-conflict inputs, fetch fault, delay, macro completion, trap inhibit, reschedule request and the two stack-overflow flags. A fixed priority chain resolves them into one response.

The response has several parts. There is a next micro-state class and an encoded exception code. There is a trap vector byte. There are also the pipeline kill, hold and cycle controls, with the two not-step controls derived from those.

The chain and the terms it derives are combinational: the operand interlock, macro done and fetch-stack overflow. A single register stage follows them. Everything the block sampled in cycle t appears on the outputs after the next rising edge. A synchronous reset clears that register.

Top module: `exc_prio_ctrl`

## Requirements
- R1: When several conditions are active, only the highest one acts. The order, highest first, is:
  - resetting, then was-resetting
  - bus fault, then bus reject
  - ALU condition, then interlock
  - fetch fault, then delayed
  - not done, then inhibit
  - reschedule, then fetch-stack overflow
  - execution-stack overflow, then default
- R2: Resetting and was-resetting give state EXC (1) with code 1 and code 2 respectively. Both use the reset vector and assert kill1 and kill23.
- R3: A nonzero bus-fault code (0 means no fault) gives state EXC with code 3 and the bus vector. It sets trap_fault, kill1 and kill23.
- R4: Bus reject gives state LAST (2) with delay, cycle0 and cycle123 set. The code and the vector are 0.
- R5: A true ALU condition acts according to the condition effect. The effect encoding is 0 none, 1 trap, 2 macro jump and 3 micro jump.
  - Trap gives EXC with code 4, the condition vector and trap_cond.
  - Macro jump gives EXC with code 5 and vector 0.
  - Micro jump gives state UBR (5).
  - All three set kill1 and kill23.
  - Effect none drives every output to 0.
- R6: The interlock is active in any of three cases:
  - a level-2 read while the A register hits stage 2
  - a level-2 read while the B register hits stage 2, pass-right is false and K is not the right operand
  - a field op with the C register as field
  
  Pass-right means the no-pass-on-A-zero flag is clear and A is zero. An active interlock gives state LAST with delay, cycle0 and kill1 set, and vector 0.
- R7: A fetch fault gives EXC with code 6 and the fetch vector. No kills are asserted.
- R8: Delayed gives LAST with the default vector. Not done gives LAST1 (3) with the default vector. Done means hold-next is clear or a macro jump is requested.
- R9: Trap inhibit, and the case where no condition is active, both give state ZERO (4) with the default vector.
- R10: Each of these gives EXC with its own code and vector:
  - reschedule: code 7
  - fetch-stack overflow: code 8. It applies when the fetch-stack flag is set and either a push is pending or no pop is pending.
  - execution-stack overflow: code 9
- R11: nostep1 equals cycle123 OR kill1. nostep23 equals cycle123 OR kill23.
- R12: Outputs change only one rising edge after their inputs. A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset of the output register |
| in_resetting | input | 1 | reset in progress |
| in_was_resetting | input | 1 | reset just finished |
| in_bus_fault | input | FAULT_W | bus fault code, 0 = none |
| in_bus_reject | input | 1 | bus rejected the request |
| in_alu_cond | input | 1 | ALU condition result true |
| in_cond_effect | input | 2 | condition effect (0 none, 1 trap, 2 macro jump, 3 micro jump) |
| in_rd_lvl2 | input | 1 | level-2 read pending |
| in_a_hit2 | input | 1 | A register matches stage 2 |
| in_b_hit2 | input | 1 | B register matches stage 2 |
| in_k_right | input | 1 | K is the right operand |
| in_no_pass_az | input | 1 | suppress pass-right when A is zero |
| in_a_zero | input | 1 | A is zero |
| in_field_op | input | 1 | field ALU operation |
| in_c_field | input | 1 | C register is the field register |
| in_fetch_fault | input | 1 | instruction fetch fault |
| in_delayed | input | 1 | delayed cycle |
| in_hold_next | input | 1 | do not fetch the next macro |
| in_macro_jump | input | 1 | macro jump requested |
| in_inhibit | input | 1 | traps inhibited |
| in_resched | input | 1 | reschedule waiting |
| in_fstk_flag | input | 1 | fetch-stack overflow flag |
| in_push_pend | input | 1 | push pending |
| in_pop_pend | input | 1 | pop pending |
| in_estk_flag | input | 1 | execution-stack overflow |
| out_state | output | 3 | state class (0 NONE, 1 EXC, 2 LAST, 3 LAST1, 4 ZERO, 5 UBR) |
| out_delay | output | 1 | delay |
| out_code | output | 4 | exception code |
| out_vector | output | 8 | trap vector byte |
| out_kill1 | output | 1 | kill stage 1 |
| out_kill23 | output | 1 | kill stages 2 and 3 |
| out_cycle0 | output | 1 | cycle-0 hold |
| out_cycle123 | output | 1 | cycle-123 hold |
| out_trap_fault | output | 1 | trap-or-fault flag |
| out_trap_cond | output | 1 | trap-or-condition flag |
| out_nostep1 | output | 1 | stage 1 does not step |
| out_nostep23 | output | 1 | stages 2 and 3 do not step |

## Verification
The assertions run on every cycle and cover these properties:
- the not-step relations
- the reset and bus-reject responses one edge after their inputs
- trap_fault and trap_cond never both set
- state EXC exactly when the code is nonzero
- cleared outputs after reset

Only the bench scenarios can show the full priority order, the three interlock cases against the pass-right term, and the fetch-stack overflow term. They can also show the exact vector chosen for each case, and that an ALU condition with no effect silences every output.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W = 4;
  localparam int VEC_W  = 8;

  typedef enum logic [2:0] {
    ST_NONE  = 3'd0,
    ST_EXC   = 3'd1,
    ST_LAST  = 3'd2,
    ST_LAST1 = 3'd3,
    ST_ZERO  = 3'd4,
    ST_UBR   = 3'd5
  } st_e;

  localparam logic [CODE_W-1:0] C_NONE   = 4'd0;
  localparam logic [CODE_W-1:0] C_RSTING = 4'd1;
  localparam logic [CODE_W-1:0] C_RSTED  = 4'd2;
  localparam logic [CODE_W-1:0] C_BUS    = 4'd3;
  localparam logic [CODE_W-1:0] C_CTRAP  = 4'd4;
  localparam logic [CODE_W-1:0] C_CJUMP  = 4'd5;
  localparam logic [CODE_W-1:0] C_FETCH  = 4'd6;
  localparam logic [CODE_W-1:0] C_RESCH  = 4'd7;
  localparam logic [CODE_W-1:0] C_FSTK   = 4'd8;
  localparam logic [CODE_W-1:0] C_ESTK   = 4'd9;

  localparam logic [1:0] EF_NONE = 2'd0;
  localparam logic [1:0] EF_TRAP = 2'd1;
  localparam logic [1:0] EF_MJMP = 2'd2;
  localparam logic [1:0] EF_UJMP = 2'd3;

  typedef struct packed {
    st_e               st;
    logic              delay;
    logic [CODE_W-1:0] code;
    logic [VEC_W-1:0]  vec;
    logic              kill1;
    logic              kill23;
    logic              cyc0;
    logic              cyc123;
    logic              tfault;
    logic              tcond;
    logic              ns1;
    logic              ns23;
  } ctl_t;

  function automatic logic f_pass_rt(input logic no_pass_az, input logic a_zero);
    return !no_pass_az && a_zero;
  endfunction

  function automatic logic f_interlock(input logic rd2, input logic a2, input logic b2,
                                       input logic k_right, input logic pass_rt,
                                       input logic fop, input logic cfld);
    return (rd2 && a2) || (rd2 && b2 && !pass_rt && !k_right) || (fop && cfld);
  endfunction

  function automatic logic f_done(input logic hold_next, input logic mjump);
    return !hold_next || mjump;
  endfunction

  function automatic logic f_fstk(input logic flag, input logic push, input logic pop);
    return flag && (push || !pop);
  endfunction

  function automatic ctl_t f_steps(input ctl_t c);
    ctl_t r;
    r      = c;
    r.ns1  = c.cyc123 || c.kill1;
    r.ns23 = c.cyc123 || c.kill23;
    return r;
  endfunction
endpackage

// File: rtl/exc_cond_decode.sv
module exc_cond_decode (
  input  logic rd2,
  input  logic a_hit2,
  input  logic b_hit2,
  input  logic k_right,
  input  logic no_pass_az,
  input  logic a_zero,
  input  logic field_op,
  input  logic c_field,
  input  logic hold_next,
  input  logic macro_jump,
  input  logic fstk_flag,
  input  logic push_pend,
  input  logic pop_pend,
  output logic pass_rt,
  output logic interlock,
  output logic done,
  output logic fstk_ovf
);
  import exc_pkg::*;

  always_comb begin
    pass_rt   = f_pass_rt(no_pass_az, a_zero);
    interlock = f_interlock(rd2, a_hit2, b_hit2, k_right, pass_rt, field_op, c_field);
    done      = f_done(hold_next, macro_jump);
    fstk_ovf  = f_fstk(fstk_flag, push_pend, pop_pend);
  end
endmodule

// File: rtl/exc_prio_select.sv
module exc_prio_select #(
  parameter int FAULT_W = 2,
  parameter logic [7:0] VEC_RESET   = 8'h01,
  parameter logic [7:0] VEC_BUS     = 8'h10,
  parameter logic [7:0] VEC_COND    = 8'h20,
  parameter logic [7:0] VEC_FETCH   = 8'h30,
  parameter logic [7:0] VEC_RESCH   = 8'h40,
  parameter logic [7:0] VEC_FSTK    = 8'h50,
  parameter logic [7:0] VEC_ESTK    = 8'h60,
  parameter logic [7:0] VEC_DEFAULT = 8'h70
) (
  input  logic               resetting,
  input  logic               was_resetting,
  input  logic [FAULT_W-1:0] bus_fault,
  input  logic               bus_reject,
  input  logic               alu_cond,
  input  logic [1:0]         cond_effect,
  input  logic               interlock,
  input  logic               fetch_fault,
  input  logic               delayed,
  input  logic               done,
  input  logic               inhibit,
  input  logic               resched,
  input  logic               fstk_ovf,
  input  logic               estk_flag,
  output exc_pkg::ctl_t      nxt
);
  import exc_pkg::*;

  ctl_t raw;

  always_comb begin
    raw = '0;
    if (resetting) begin
      raw.st = ST_EXC; raw.code = C_RSTING; raw.vec = VEC_RESET;
      raw.kill1 = 1'b1; raw.kill23 = 1'b1;
    end else if (was_resetting) begin
      raw.st = ST_EXC; raw.code = C_RSTED; raw.vec = VEC_RESET;
      raw.kill1 = 1'b1; raw.kill23 = 1'b1;
    end else if (bus_fault != '0) begin
      raw.st = ST_EXC; raw.code = C_BUS; raw.vec = VEC_BUS; raw.tfault = 1'b1;
      raw.kill1 = 1'b1; raw.kill23 = 1'b1;
    end else if (bus_reject) begin
      raw.st = ST_LAST; raw.delay = 1'b1; raw.cyc0 = 1'b1; raw.cyc123 = 1'b1;
    end else if (alu_cond) begin
      unique case (cond_effect)
        EF_TRAP: begin
          raw.st = ST_EXC; raw.code = C_CTRAP; raw.vec = VEC_COND; raw.tcond = 1'b1;
          raw.kill1 = 1'b1; raw.kill23 = 1'b1;
        end
        EF_MJMP: begin
          raw.st = ST_EXC; raw.code = C_CJUMP;
          raw.kill1 = 1'b1; raw.kill23 = 1'b1;
        end
        EF_UJMP: begin
          raw.st = ST_UBR; raw.kill1 = 1'b1; raw.kill23 = 1'b1;
        end
        default: raw = '0;
      endcase
    end else if (interlock) begin
      raw.st = ST_LAST; raw.delay = 1'b1; raw.cyc0 = 1'b1; raw.kill1 = 1'b1;
    end else if (fetch_fault) begin
      raw.st = ST_EXC; raw.code = C_FETCH; raw.vec = VEC_FETCH;
    end else if (delayed) begin
      raw.st = ST_LAST; raw.vec = VEC_DEFAULT;
    end else if (!done) begin
      raw.st = ST_LAST1; raw.vec = VEC_DEFAULT;
    end else if (inhibit) begin
      raw.st = ST_ZERO; raw.vec = VEC_DEFAULT;
    end else if (resched) begin
      raw.st = ST_EXC; raw.code = C_RESCH; raw.vec = VEC_RESCH;
    end else if (fstk_ovf) begin
      raw.st = ST_EXC; raw.code = C_FSTK; raw.vec = VEC_FSTK;
    end else if (estk_flag) begin
      raw.st = ST_EXC; raw.code = C_ESTK; raw.vec = VEC_ESTK;
    end else begin
      raw.st = ST_ZERO; raw.vec = VEC_DEFAULT;
    end
    nxt = f_steps(raw);
  end
endmodule

// File: rtl/exc_out_reg.sv
module exc_out_reg (
  input  logic          clk,
  input  logic          rst,
  input  exc_pkg::ctl_t d,
  output exc_pkg::ctl_t q
);
  import exc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  p_nostep1_r11: assert property (@(posedge clk) disable iff (rst)
    q.ns1 == (q.cyc123 || q.kill1));
  p_nostep23_r11: assert property (@(posedge clk) disable iff (rst)
    q.ns23 == (q.cyc123 || q.kill23));
  p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(q.tfault && q.tcond));
  p_code_state_r1: assert property (@(posedge clk) disable iff (rst)
    (q.code != '0) == (q.st == ST_EXC));
endmodule

// File: rtl/exc_prio_ctrl.sv
module exc_prio_ctrl #(
  parameter int FAULT_W = 2,
  parameter logic [7:0] VEC_RESET   = 8'h01,
  parameter logic [7:0] VEC_BUS     = 8'h10,
  parameter logic [7:0] VEC_COND    = 8'h20,
  parameter logic [7:0] VEC_FETCH   = 8'h30,
  parameter logic [7:0] VEC_RESCH   = 8'h40,
  parameter logic [7:0] VEC_FSTK    = 8'h50,
  parameter logic [7:0] VEC_ESTK    = 8'h60,
  parameter logic [7:0] VEC_DEFAULT = 8'h70
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_resetting,
  input  logic               in_was_resetting,
  input  logic [FAULT_W-1:0] in_bus_fault,
  input  logic               in_bus_reject,
  input  logic               in_alu_cond,
  input  logic [1:0]         in_cond_effect,
  input  logic               in_rd_lvl2,
  input  logic               in_a_hit2,
  input  logic               in_b_hit2,
  input  logic               in_k_right,
  input  logic               in_no_pass_az,
  input  logic               in_a_zero,
  input  logic               in_field_op,
  input  logic               in_c_field,
  input  logic               in_fetch_fault,
  input  logic               in_delayed,
  input  logic               in_hold_next,
  input  logic               in_macro_jump,
  input  logic               in_inhibit,
  input  logic               in_resched,
  input  logic               in_fstk_flag,
  input  logic               in_push_pend,
  input  logic               in_pop_pend,
  input  logic               in_estk_flag,
  output logic [2:0]         out_state,
  output logic               out_delay,
  output logic [3:0]         out_code,
  output logic [7:0]         out_vector,
  output logic               out_kill1,
  output logic               out_kill23,
  output logic               out_cycle0,
  output logic               out_cycle123,
  output logic               out_trap_fault,
  output logic               out_trap_cond,
  output logic               out_nostep1,
  output logic               out_nostep23
);
  import exc_pkg::*;

  logic pass_rt, interlock, done, fstk_ovf;
  ctl_t nxt, cur;

  exc_cond_decode u_dec (
    .rd2(in_rd_lvl2), .a_hit2(in_a_hit2), .b_hit2(in_b_hit2), .k_right(in_k_right),
    .no_pass_az(in_no_pass_az), .a_zero(in_a_zero), .field_op(in_field_op),
    .c_field(in_c_field), .hold_next(in_hold_next), .macro_jump(in_macro_jump),
    .fstk_flag(in_fstk_flag), .push_pend(in_push_pend), .pop_pend(in_pop_pend),
    .pass_rt(pass_rt), .interlock(interlock), .done(done), .fstk_ovf(fstk_ovf)
  );

  exc_prio_select #(
    .FAULT_W(FAULT_W), .VEC_RESET(VEC_RESET), .VEC_BUS(VEC_BUS), .VEC_COND(VEC_COND),
    .VEC_FETCH(VEC_FETCH), .VEC_RESCH(VEC_RESCH), .VEC_FSTK(VEC_FSTK),
    .VEC_ESTK(VEC_ESTK), .VEC_DEFAULT(VEC_DEFAULT)
  ) u_sel (
    .resetting(in_resetting), .was_resetting(in_was_resetting), .bus_fault(in_bus_fault),
    .bus_reject(in_bus_reject), .alu_cond(in_alu_cond), .cond_effect(in_cond_effect),
    .interlock(interlock), .fetch_fault(in_fetch_fault), .delayed(in_delayed),
    .done(done), .inhibit(in_inhibit), .resched(in_resched), .fstk_ovf(fstk_ovf),
    .estk_flag(in_estk_flag), .nxt(nxt)
  );

  exc_out_reg u_reg (.clk(clk), .rst(rst), .d(nxt), .q(cur));

  assign out_state      = cur.st;
  assign out_delay      = cur.delay;
  assign out_code       = cur.code;
  assign out_vector     = cur.vec;
  assign out_kill1      = cur.kill1;
  assign out_kill23     = cur.kill23;
  assign out_cycle0     = cur.cyc0;
  assign out_cycle123   = cur.cyc123;
  assign out_trap_fault = cur.tfault;
  assign out_trap_cond  = cur.tcond;
  assign out_nostep1    = cur.ns1;
  assign out_nostep23   = cur.ns23;

  p_reset_kill_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_resetting) |-> (out_kill1 && out_kill23 && out_vector == VEC_RESET
                                     && out_state == 3'd1));
  p_reject_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !in_resetting && !in_was_resetting && in_bus_fault == '0 && in_bus_reject)
      |-> (out_state == 3'd2 && out_delay && out_cycle0 && out_cycle123 && out_code == 4'd0));
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_state == 3'd0 && out_vector == 8'd0 && !out_kill1 && !out_nostep23));
endmodule

// File: tb/test_exc_prio_ctrl.sv
module test_exc_prio_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [25:0] s = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  logic [2:0] o_st; logic o_dly; logic [3:0] o_code; logic [7:0] o_vec;
  logic o_k1, o_k23, o_c0, o_c123, o_tf, o_tc, o_n1, o_n23;

  exc_prio_ctrl i_exc_prio_ctrl (
    .clk(clk), .rst(rst),
    .in_resetting(s[0]), .in_was_resetting(s[1]), .in_bus_fault(s[3:2]),
    .in_bus_reject(s[4]), .in_alu_cond(s[5]), .in_cond_effect(s[7:6]),
    .in_rd_lvl2(s[8]), .in_a_hit2(s[9]), .in_b_hit2(s[10]), .in_k_right(s[11]),
    .in_no_pass_az(s[12]), .in_a_zero(s[13]), .in_field_op(s[14]), .in_c_field(s[15]),
    .in_fetch_fault(s[16]), .in_delayed(s[17]), .in_hold_next(s[18]),
    .in_macro_jump(s[19]), .in_inhibit(s[20]), .in_resched(s[21]),
    .in_fstk_flag(s[22]), .in_push_pend(s[23]), .in_pop_pend(s[24]), .in_estk_flag(s[25]),
    .out_state(o_st), .out_delay(o_dly), .out_code(o_code), .out_vector(o_vec),
    .out_kill1(o_k1), .out_kill23(o_k23), .out_cycle0(o_c0), .out_cycle123(o_c123),
    .out_trap_fault(o_tf), .out_trap_cond(o_tc), .out_nostep1(o_n1), .out_nostep23(o_n23)
  );

  // expected bundle: {st,dly,code,vec,k1,k23,c0,c123,tf,tc,n1,n23}
  function automatic logic [23:0] pack(int st, bit d, int code, int vec,
                                       bit k1, bit k23, bit c0, bit c123, bit tf, bit tc);
    return {st[2:0], d, code[3:0], vec[7:0], k1, k23, c0, c123, tf, tc, c123 | k1, c123 | k23};
  endfunction

  function automatic int level(logic [25:0] v);
    bit ilk, fo;
    bit act [14];
    ilk = (v[8] & v[9]) | (v[8] & v[10] & ~(~v[12] & v[13]) & ~v[11]) | (v[14] & v[15]);
    fo  = v[22] & (v[23] | ~v[24]);
    act[0] = v[0]; act[1] = v[1]; act[2] = |v[3:2]; act[3] = v[4]; act[4] = v[5];
    act[5] = ilk; act[6] = v[16]; act[7] = v[17]; act[8] = v[18] & ~v[19];
    act[9] = v[20]; act[10] = v[21]; act[11] = fo; act[12] = v[25]; act[13] = 1'b1;
    for (int i = 0; i < 14; i++) if (act[i]) return i;
    return 13;
  endfunction

  function automatic logic [23:0] model(logic [25:0] v);
    case (level(v))
      0:  return pack(1, 0, 1, 8'h01, 1, 1, 0, 0, 0, 0);
      1:  return pack(1, 0, 2, 8'h01, 1, 1, 0, 0, 0, 0);
      2:  return pack(1, 0, 3, 8'h10, 1, 1, 0, 0, 1, 0);
      3:  return pack(2, 1, 0, 0, 0, 0, 1, 1, 0, 0);
      4:  case (v[7:6])
            2'd1: return pack(1, 0, 4, 8'h20, 1, 1, 0, 0, 0, 1);
            2'd2: return pack(1, 0, 5, 0, 1, 1, 0, 0, 0, 0);
            2'd3: return pack(5, 0, 0, 0, 1, 1, 0, 0, 0, 0);
            default: return 24'd0;
          endcase
      5:  return pack(2, 1, 0, 0, 1, 0, 1, 0, 0, 0);
      6:  return pack(1, 0, 6, 8'h30, 0, 0, 0, 0, 0, 0);
      7:  return pack(2, 0, 0, 8'h70, 0, 0, 0, 0, 0, 0);
      8:  return pack(3, 0, 0, 8'h70, 0, 0, 0, 0, 0, 0);
      9:  return pack(4, 0, 0, 8'h70, 0, 0, 0, 0, 0, 0);
      10: return pack(1, 0, 7, 8'h40, 0, 0, 0, 0, 0, 0);
      11: return pack(1, 0, 8, 8'h50, 0, 0, 0, 0, 0, 0);
      12: return pack(1, 0, 9, 8'h60, 0, 0, 0, 0, 0, 0);
      default: return pack(4, 0, 0, 8'h70, 0, 0, 0, 0, 0, 0);
    endcase
  endfunction

  function automatic string tag(int l);
    case (l)
      0, 1: return "R2"; 2: return "R3"; 3: return "R4"; 4: return "R5"; 5: return "R6";
      6: return "R7"; 7, 8: return "R8"; 10, 11, 12: return "R10"; default: return "R9";
    endcase
  endfunction

  function automatic logic [23:0] actual();
    return {o_st, o_dly, o_code, o_vec, o_k1, o_k23, o_c0, o_c123, o_tf, o_tc, o_n1, o_n23};
  endfunction

  // R12: value driven now appears after one rising edge, sampled at next falling edge
  task automatic apply(logic [25:0] v);
    logic [23:0] exp;
    s = v;
    @(negedge clk);
    exp = model(v);
    n_chk++;
    if (actual() !== exp) begin
      n_bad++;
      $display("FAIL R1 %s R11 stim=%h actual=%h expected=%h", tag(level(v)), v, actual(), exp);
    end
  endtask

  function automatic logic [25:0] rnd();
    logic [25:0] v;
    v = 26'($urandom);
    v[0]  = ($urandom % 8) == 0; v[1]  = ($urandom % 8) == 0;
    v[3:2] = (($urandom % 6) == 0) ? 2'(1 + $urandom % 3) : 2'd0;
    v[4]  = ($urandom % 6) == 0; v[5]  = ($urandom % 5) == 0;
    v[16] = ($urandom % 4) == 0; v[17] = ($urandom % 4) == 0;
    v[20] = ($urandom % 3) == 0; v[21] = ($urandom % 3) == 0;
    return v;
  endfunction

  // clear everything above target level t, then make t active
  function automatic logic [25:0] target(logic [25:0] v, int t);
    if (t > 0)  v[0] = 0;
    if (t > 1)  v[1] = 0;
    if (t > 2)  v[3:2] = 0;
    if (t > 3)  v[4] = 0;
    if (t > 4)  v[5] = 0;
    if (t > 5)  begin v[8] = 0; v[14] = 0; end
    if (t > 6)  v[16] = 0;
    if (t > 7)  v[17] = 0;
    if (t > 8)  v[18] = 0;
    if (t > 9)  v[20] = 0;
    if (t > 10) v[21] = 0;
    if (t > 11) v[22] = 0;
    if (t > 12) v[25] = 0;
    case (t)
      0: v[0] = 1; 1: v[1] = 1; 2: v[3:2] = 2'(1 + $urandom % 3); 3: v[4] = 1; 4: v[5] = 1;
      5: begin v[14] = 1; v[15] = 1; end
      6: v[16] = 1; 7: v[17] = 1; 8: begin v[18] = 1; v[19] = 0; end
      9: v[20] = 1; 10: v[21] = 1; 11: begin v[22] = 1; v[23] = 1; end 12: v[25] = 1;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #300000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [25:0] v;
    s = 26'h3FFFFFF;
    repeat (3) @(negedge clk);
    n_chk++;  // R12 reset clears outputs
    if (actual() !== 24'd0) begin
      n_bad++; $display("FAIL R12 reset actual=%h expected=0", actual());
    end
    rst = 1'b0;
    // R5 ALU condition, every effect, lower conditions random
    for (int e = 0; e < 4; e++) begin
      v = target(rnd(), 4); v[7:6] = 2'(e); apply(v);
    end
    // R6 interlock inputs exhaustive
    for (int i = 0; i < 256; i++) begin
      v = target(rnd(), 6); v[16] = 0; v[8] = i[0]; v[9] = i[1]; v[10] = i[2];
      v[11] = i[3]; v[12] = i[4]; v[13] = i[5]; v[14] = i[6]; v[15] = i[7];
      v[16] = 1; apply(v);
    end
    // R8 done and R10 fetch-stack term exhaustive
    for (int i = 0; i < 32; i++) begin
      v = target(rnd(), 8); v[18] = i[0]; v[19] = i[1];
      v[22] = i[2]; v[23] = i[3]; v[24] = i[4]; v[20] = 0; v[21] = 0; v[25] = 0;
      apply(v);
    end
    // R1 each level as winner with random lower conditions
    for (int t = 0; t < 14; t++)
      for (int k = 0; k < 300; k++) apply(target(rnd(), t));
    for (int k = 0; k < 4000; k++) apply(rnd());
    // R12 synchronous reset mid-run
    s = 26'h1; rst = 1'b1;
    @(negedge clk);
    n_chk++;
    if (actual() !== 24'd0) begin
      n_bad++; $display("FAIL R12 midrun reset actual=%h expected=0", actual());
    end
    rst = 1'b0;
    apply(26'h0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule